// File: doc/BRIEF.md
# Flagless Variable Shift Execution Unit

This unit carries out the three-operand variable shift used by the integer pipeline. It takes two 64-bit source values, one to be shifted and one that supplies the count. A 2-bit prefix code picks one of three shifts: arithmetic right, logical left or logical right. The W bit and the 64-bit-mode indicator together set the operand size to 32 or 64 bits. The count is masked to suit that size, so a count never reaches or passes the operand width. The unit has no condition-flag output of any kind, so the flags register is never written.

Each request is accepted on a one-cycle valid strobe. One cycle later the unit returns either a result with a result-valid strobe or an undefined-opcode fault strobe. The fault is raised when the L bit is set, when the core is in real or virtual-8086 mode, or when the prefix code does not name a shift. Fetch, operand decode, register-file access and memory operands belong to other units.

Top module: `shx_unit`

## Requirements
- R1: The prefix code selects the operation: 2'b10 is arithmetic right shift, 2'b01 is logical left shift, 2'b11 is logical right shift, and 2'b00 raises the undefined-opcode fault.
- R2: The operand size is 64 bits only when the W bit is 1 and the 64-bit-mode indicator is 1.
- R3: Outside 64-bit mode the W bit has no effect, and the unit works on 32-bit operands.
- R4: The count is the second source ANDed with 6'h3F for a 64-bit operand or with 5'h1F for a 32-bit operand. All higher bits of the second source are ignored.
- R5: An arithmetic right shift fills the vacated high bits with copies of the operand's sign bit, which gives signed division rounded toward negative infinity.
- R6: A logical right shift fills the vacated high bits with zeros, and a left shift fills the vacated low bits with zeros.
- R7: A request with the L bit set raises the undefined-opcode fault and yields no result.
- R8: A request made in real or virtual-8086 mode raises the undefined-opcode fault and yields no result.
- R9: For a 32-bit operand the arithmetic shift takes bit 31 as the sign bit, and the 32-bit result is zero-extended into bits 63:32 of the result.
- R10: A masked count of zero returns the source unchanged, cut to the operand size and zero-extended.
- R11: The result-valid or fault strobe is asserted exactly one cycle after an accepted valid strobe and at no other time. The result bus reads zero whenever result-valid is low. After reset all outputs are zero.
- R12: The result-valid and fault strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| in_prefix | input | 2 | Operation code (see R1) |
| in_w | input | 1 | Wide-operand request bit |
| in_l | input | 1 | Vector-length bit; must be zero |
| in_mode64 | input | 1 | Core is in 64-bit mode |
| in_legacy | input | 1 | Core is in real or virtual-8086 mode |
| src_a | input | 64 | Value to be shifted |
| src_b | input | 64 | Count source |
| res_data | output | 64 | Shift result, zero when res_valid is low |
| res_valid | output | 1 | Result strobe |
| res_ud | output | 1 | Undefined-opcode fault strobe |

## Verification
On every cycle the assertions check the following. The two strobes never coincide. The one-cycle latency holds. Each fault condition (the L bit, legacy mode) leads to the fault strobe. A narrow result never carries upper bits. A zero wide count passes the source through. The actual shift values can only be shown by the bench's sweeps, which cover every prefix, mode, W and fault combination over counts 0 to 127 and several source patterns. Those sweeps also show the sign fill, the count masking and that W has no effect outside 64-bit mode.

// File: rtl/shx_pkg.sv
// Shared types for the variable shift unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package shx_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SHL  = 2'b01,
        OP_SAR  = 2'b10,
        OP_SHR  = 2'b11
    } shx_op_e;
endpackage

// File: rtl/shx_decode.sv
// Decodes the prefix code, mode bits and W bit into an operation,
// an operand-size select and a fault flag.
// Assumes the caller samples the outputs only with a valid request.
module shx_decode
    import shx_pkg::*;
(
    input  logic [1:0] prefix,
    input  logic       w_bit,
    input  logic       l_bit,
    input  logic       mode64,
    input  logic       legacy,
    output shx_op_e    op,
    output logic       wide,
    output logic       fault
);
    // Map the prefix code onto an operation.
    always_comb begin
        case (prefix)
            2'b01:   op = OP_SHL;
            2'b10:   op = OP_SAR;
            2'b11:   op = OP_SHR;
            default: op = OP_NONE;
        endcase
    end

    // Wide operands only with W set in 64-bit mode; fault on bad encodings.
    always_comb begin
        wide  = w_bit & mode64;
        fault = l_bit | legacy | (op == OP_NONE);
    end
endmodule

// File: rtl/shx_shifter.sv
// Logarithmic right shifter with a programmable fill bit. A left shift
// is done by bit-reversing the data around the right shifter.
// Assumes W is a power of two and CNT_W = log2(W).
module shx_shifter #(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic [CNT_W-1:0] cnt,
    input  logic             left,
    input  logic             fill,
    output logic [W-1:0]     dout
);
    logic [W-1:0] rev_in;
    logic [W-1:0] stage [CNT_W+1];

    // Reverse the bit order for left shifts.
    for (genvar i = 0; i < W; i++) begin : g_rev_in
        assign rev_in[i] = din[W-1-i];
    end

    // Choose the data entering the first stage.
    always_comb stage[0] = left ? rev_in : din;

    // One stage per count bit, each moving by a power of two.
    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        always_comb begin
            if (cnt[s])
                stage[s+1] = {{STEP{fill}}, stage[s][W-1:STEP]};
            else
                stage[s+1] = stage[s];
        end
    end

    // Undo the reversal for left shifts.
    for (genvar i = 0; i < W; i++) begin : g_rev_out
        assign dout[i] = left ? stage[CNT_W][W-1-i] : stage[CNT_W][i];
    end
endmodule

// File: rtl/shx_unit.sv
// Variable shift execution unit. It decodes the request, prepares the
// operand for the chosen size, shifts it and registers the result or
// the fault. It has no flag outputs.
// Assumes a synchronous active-low reset and single-cycle request strobes.
module shx_unit
    import shx_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_prefix,
    input  logic              in_w,
    input  logic              in_l,
    input  logic              in_mode64,
    input  logic              in_legacy,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic              res_ud
);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int NCNT_W = $clog2(NARROW_W);
    localparam int HI_W   = DATA_W - NARROW_W;
    localparam logic [CNT_W-1:0] WIDE_MASK   = '1;
    localparam logic [CNT_W-1:0] NARROW_MASK =
        {{(CNT_W-NCNT_W){1'b0}}, {NCNT_W{1'b1}}};

    shx_op_e           op;
    logic              wide;
    logic              fault;
    logic [DATA_W-1:0] opnd;
    logic [CNT_W-1:0]  cnt;
    logic              fill;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] result;
    logic              unused_cnt_hi;

    shx_decode u_dec (
        .prefix (in_prefix),
        .w_bit  (in_w),
        .l_bit  (in_l),
        .mode64 (in_mode64),
        .legacy (in_legacy),
        .op     (op),
        .wide   (wide),
        .fault  (fault)
    );

    // Count bits above the wide mask take no part in the shift.
    assign unused_cnt_hi = ^src_b[DATA_W-1:CNT_W];

    // Extend the operand and mask the count for the chosen size.
    always_comb begin
        if (wide) begin
            opnd = src_a;
            cnt  = src_b[CNT_W-1:0] & WIDE_MASK;
        end else begin
            if (op == OP_SAR)
                opnd = {{HI_W{src_a[NARROW_W-1]}}, src_a[NARROW_W-1:0]};
            else
                opnd = {{HI_W{1'b0}}, src_a[NARROW_W-1:0]};
            cnt  = src_b[CNT_W-1:0] & NARROW_MASK;
        end
        fill = (op == OP_SAR) ? opnd[DATA_W-1] : 1'b0;
    end

    shx_shifter #(
        .W     (DATA_W),
        .CNT_W (CNT_W)
    ) u_shf (
        .din  (opnd),
        .cnt  (cnt),
        .left (op == OP_SHL),
        .fill (fill),
        .dout (shifted)
    );

    // Cut narrow results to the operand size with zero extension.
    always_comb begin
        if (wide)
            result = shifted;
        else
            result = {{HI_W{1'b0}}, shifted[NARROW_W-1:0]};
    end

    // Register the result or the fault one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_ud    <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= in_valid & ~fault;
            res_ud    <= in_valid & fault;
            res_data  <= (in_valid & ~fault) ? result : '0;
        end
    end
endmodule

// File: rtl/shx_unit_chk.sv
// Cycle-level properties of the shift unit, bound to every instance.
// Assumes the same parameters as the unit it watches.
module shx_unit_chk #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_prefix,
    input logic              in_w,
    input logic              in_l,
    input logic              in_mode64,
    input logic              in_legacy,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] res_data,
    input logic              res_valid,
    input logic              res_ud
);
    localparam int CNT_W = $clog2(DATA_W);

    logic good_req;
    assign good_req = in_valid && !in_l && !in_legacy && (in_prefix != 2'b00);

    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_ud));

    a_r11_answer_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_valid || res_ud));

    a_r11_quiet_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !res_ud && res_data == '0));

    a_r7_l_bit_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_l) |=> (res_ud && !res_valid && res_data == '0));

    a_r8_legacy_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_legacy) |=> (res_ud && !res_valid));

    a_r9_narrow_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (good_req && !(in_w && in_mode64)) |=> (res_data[DATA_W-1:NARROW_W] == '0));

    a_r10_zero_count_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (good_req && in_w && in_mode64 && src_b[CNT_W-1:0] == '0)
        |=> (res_valid && res_data == $past(src_a)));
endmodule

bind shx_unit shx_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/sim_shx_unit.sv
// Sweeps every prefix, mode, W, L and legacy combination over counts
// 0..127 and several source patterns, comparing with an arithmetic model.
module sim_shx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_prefix = 2'b00;
    logic        in_w = 1'b0;
    logic        in_l = 1'b0;
    logic        in_mode64 = 1'b0;
    logic        in_legacy = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] res_data;
    logic        res_valid;
    logic        res_ud;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    shx_unit u0 (.*);

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] pats [4];
        pats[0] = 64'h8000_0000_8000_0001;
        pats[1] = 64'hFFFF_FFFF_7FFF_FFFF;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        pats[3] = 64'hF0E1_D2C3_B4A5_9687;

        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset valid", {63'b0, res_valid}, 64'b0);
        check("R11 reset fault", {63'b0, res_ud}, 64'b0);
        check("R11 reset data", res_data, 64'b0);
        rst_n = 1'b1;

        for (int p = 0; p < 4; p++)
        for (int cfg = 0; cfg < 16; cfg++)
        for (int k = 0; k < 4; k++)
        for (int c = 0; c < 128; c++) begin
            logic        w, m64, l, leg, wide, flt;
            logic [5:0]  cnt;
            logic [63:0] a, b, exp;
            logic signed [63:0] sa;
            logic signed [31:0] sn;
            string tag;
            w   = cfg[0];
            m64 = cfg[1];
            l   = cfg[2];
            leg = cfg[3];
            a   = pats[k];
            b   = {57'h1_2345_6789_ABCD ^ {53'b0, k[3:0]}, c[6:0]};
            wide = w & m64;
            cnt  = wide ? b[5:0] : {1'b0, b[4:0]};
            flt  = l | leg | (p == 0);
            sa   = $signed(a);
            sn   = $signed(a[31:0]);
            // Arithmetic model of the requirements.
            if (flt) exp = 64'b0;
            else if (wide) begin
                case (p)
                    1: exp = a << cnt;
                    2: exp = sa >>> cnt;
                    default: exp = a >> cnt;
                endcase
            end else begin
                case (p)
                    1: exp = {32'b0, a[31:0] << cnt[4:0]};
                    2: exp = {32'b0, 32'(sn >>> cnt[4:0])};
                    default: exp = {32'b0, a[31:0] >> cnt[4:0]};
                endcase
            end
            if (l) tag = "R7";
            else if (leg) tag = "R8";
            else if (p == 0) tag = "R1";
            else begin
                tag = (p == 2) ? "R5" : "R6";
                if (wide) tag = {tag, "/R2"};
                else if (w) tag = {tag, "/R3"};
                else tag = {tag, "/R9"};
                if (cnt == 0) tag = {tag, "/R10"};
                if ({1'b0, c[6:0]} > (wide ? 8'd63 : 8'd31)) tag = {tag, "/R4"};
            end

            @(negedge clk);
            in_valid = 1'b1; in_prefix = p[1:0]; in_w = w; in_l = l;
            in_mode64 = m64; in_legacy = leg; src_a = a; src_b = b;
            @(negedge clk);
            in_valid = 1'b0;
            check({tag, " data"}, res_data, exp);
            check({tag, " strobes"}, {62'b0, res_valid, res_ud},
                  {62'b0, ~flt, flt});
            // R12: strobes exclusive
            check("R12 exclusive", {63'b0, res_valid & res_ud}, 64'b0);
            if (c == 127) begin
                @(negedge clk);
                // R11: nothing follows without a request
                check("R11 idle", {res_data[62:0] | 63'b0, res_valid | res_ud},
                      64'b0);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule